// File: doc/BRIEF.md
# Delay-Line DMA Sequencer

This block carries out one delay-line access against an external buffer with no help from the core once the access starts. Software loads a handful of parameter registers: the internal pointer and its step, the external pointer and its step, a write count, a read count and a read pointer. It then pulses start. The sequencer first copies a block of words from internal memory to the external delay line. It then fetches a block from the external buffer and stores it back into internal memory.

The two phases run back to back. The internal pointer does not restart between them, so the words read back land directly after the words sent out. Each word makes two memory transfers in order: a fetch and then a store. Every transfer is a request held until its acknowledge arrives. Only one request is ever open. When the last store finishes, a single-cycle done pulse marks the end of the access and the sequencer goes idle.

Top module: `dly_dma_seq`

## Requirements
- R1: After reset, and while idle, `busy_o`, `done_o`, `imem_req_o` and `emem_req_o` are all low.
- R2: During the write phase, each of the write-count words first makes an internal read at the internal pointer. It then makes an external write (`emem_we_o`=1) carrying the word just read. Exactly write-count external writes occur.
- R3: After each completed internal transfer in either phase, the internal pointer moves by the internal step. The step is two's complement and the pointer wraps at `IADDR_W` bits. The read phase continues from where the write phase left off.
- R4: The first external write goes to the programmed external pointer. Each later write goes to the previous address plus the external step, two's complement and wrapping at `EADDR_W` bits.
- R5: After the write phase, each of the read-count words first makes an external read (`emem_we_o`=0). The read starts at the read pointer and moves by the external step after each word. It is followed by an internal write (`imem_we_o`=1) of the returned data.
- R6: A zero write count skips the write phase. A zero read count skips the read phase. If both are zero, `done_o` rises in the cycle after start is sampled.
- R7: `done_o` is high for exactly one cycle, in the cycle after the acknowledge of the final transfer. `busy_o` is low in the next cycle.
- R8: Parameter writes and start pulses that arrive while `busy_o` is high are discarded. They affect neither the running access nor the next one.
- R9: `imem_req_o` and `emem_req_o` are never high together. A request keeps its address until its acknowledge.
- R10: Parameter select codes are: 0 internal pointer, 1 internal step, 2 write count, 3 external pointer, 4 external step, 5 read count, 6 read pointer. Code 7 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Parameter write strobe |
| cfg_sel_i | input | 3 | Parameter select (R10) |
| cfg_wdata_i | input | CFG_W | Parameter value, low bits used |
| start_i | input | 1 | Start pulse, sampled when idle |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| imem_req_o | output | 1 | Internal memory request |
| imem_we_o | output | 1 | Internal request is a write |
| imem_addr_o | output | IADDR_W | Internal address |
| imem_wdata_o | output | DATA_W | Internal write data |
| imem_rdata_i | input | DATA_W | Internal read data, valid with ack |
| imem_ack_i | input | 1 | Internal request completed |
| emem_req_o | output | 1 | External memory request |
| emem_we_o | output | 1 | External request is a write |
| emem_addr_o | output | EADDR_W | External address |
| emem_wdata_o | output | DATA_W | External write data |
| emem_rdata_i | input | DATA_W | External read data, valid with ack |
| emem_ack_i | input | 1 | External request completed |

## Verification
The properties assume that each acknowledge is raised only while its own request is high, and lasts a single cycle. They also assume read data is valid in the acknowledge cycle. The bench memory models keep to this. Each model raises its acknowledge one cycle or more after it sees a request, and drops it at the following edge. The latency varies randomly from zero to two extra cycles. Read data is a pure function of the address presented. Parameter writes and start pulses during an access are made only while `busy_o` is high and the access still has transfers left.

// File: rtl/dly_dma_pkg.sv
package dly_dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_IRD  = 3'd1,
    ST_EWR  = 3'd2,
    ST_ERD  = 3'd3,
    ST_IWR  = 3'd4,
    ST_DONE = 3'd5
  } state_e;

  typedef enum logic [2:0] {
    SEL_IPTR = 3'd0,
    SEL_ISTP = 3'd1,
    SEL_WCNT = 3'd2,
    SEL_EPTR = 3'd3,
    SEL_ESTP = 3'd4,
    SEL_RCNT = 3'd5,
    SEL_RPTR = 3'd6
  } sel_e;
endpackage

// File: rtl/dly_dma_regs.sv
module dly_dma_regs #(
  parameter int IADDR_W = 12,
  parameter int EADDR_W = 16,
  parameter int CNT_W   = 8,
  parameter int CFG_W   = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [2:0]         sel_i,
  input  logic [CFG_W-1:0]   wdata_i,
  input  logic               lock_i,
  output logic [IADDR_W-1:0] iptr_o,
  output logic [IADDR_W-1:0] istp_o,
  output logic [CNT_W-1:0]   wcnt_o,
  output logic [EADDR_W-1:0] eptr_o,
  output logic [EADDR_W-1:0] estp_o,
  output logic [CNT_W-1:0]   rcnt_o,
  output logic [EADDR_W-1:0] rptr_o
);
  import dly_dma_pkg::*;

  logic wr;
  assign wr = we_i && !lock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iptr_o <= '0;
      istp_o <= '0;
      wcnt_o <= '0;
      eptr_o <= '0;
      estp_o <= '0;
      rcnt_o <= '0;
      rptr_o <= '0;
    end else if (wr) begin
      case (sel_e'(sel_i))
        SEL_IPTR: iptr_o <= wdata_i[IADDR_W-1:0];
        SEL_ISTP: istp_o <= wdata_i[IADDR_W-1:0];
        SEL_WCNT: wcnt_o <= wdata_i[CNT_W-1:0];
        SEL_EPTR: eptr_o <= wdata_i[EADDR_W-1:0];
        SEL_ESTP: estp_o <= wdata_i[EADDR_W-1:0];
        SEL_RCNT: rcnt_o <= wdata_i[CNT_W-1:0];
        SEL_RPTR: rptr_o <= wdata_i[EADDR_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dly_dma_ptr.sv
module dly_dma_ptr #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  input  logic [W-1:0] stp_i,
  output logic [W-1:0] ptr_o
);
  // step wraps modulo 2^W, so a negative step is its two's complement
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (load_i) ptr_o <= load_val_i;
    else if (step_i) ptr_o <= ptr_o + stp_i;
  end
endmodule

// File: rtl/dly_dma_ctrl.sv
module dly_dma_ctrl #(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  wcnt_i,
  input  logic [CNT_W-1:0]  rcnt_i,
  input  logic              imem_ack_i,
  input  logic              emem_ack_i,
  input  logic [DATA_W-1:0] imem_rdata_i,
  input  logic [DATA_W-1:0] emem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              imem_req_o,
  output logic              imem_we_o,
  output logic              emem_req_o,
  output logic              emem_we_o,
  output logic [DATA_W-1:0] buf_o,
  output logic              load_o,
  output logic              istep_o,
  output logic              ewstep_o,
  output logic              erstep_o
);
  import dly_dma_pkg::*;

  state_e           state_q, state_d;
  logic [CNT_W-1:0] wrem_q, rrem_q;

  assign load_o   = (state_q == ST_IDLE) && start_i;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = (state_q == ST_DONE);
  assign imem_req_o = (state_q == ST_IRD) || (state_q == ST_IWR);
  assign imem_we_o  = (state_q == ST_IWR);
  assign emem_req_o = (state_q == ST_EWR) || (state_q == ST_ERD);
  assign emem_we_o  = (state_q == ST_EWR);
  assign istep_o  = imem_req_o && imem_ack_i;
  assign ewstep_o = (state_q == ST_EWR) && emem_ack_i;
  assign erstep_o = (state_q == ST_ERD) && emem_ack_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_i) begin
        if (wcnt_i != '0)      state_d = ST_IRD;
        else if (rcnt_i != '0) state_d = ST_ERD;
        else                   state_d = ST_DONE;
      end
      ST_IRD: if (imem_ack_i) state_d = ST_EWR;
      ST_EWR: if (emem_ack_i) begin
        if (wrem_q != CNT_W'(1)) state_d = ST_IRD;
        else if (rrem_q != '0)   state_d = ST_ERD;
        else                     state_d = ST_DONE;
      end
      ST_ERD: if (emem_ack_i) state_d = ST_IWR;
      ST_IWR: if (imem_ack_i) state_d = (rrem_q == CNT_W'(1)) ? ST_DONE : ST_ERD;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wrem_q  <= '0;
      rrem_q  <= '0;
      buf_o   <= '0;
    end else begin
      state_q <= state_d;
      if (load_o) begin
        wrem_q <= wcnt_i;
        rrem_q <= rcnt_i;
      end
      if (ewstep_o) wrem_q <= wrem_q - CNT_W'(1);
      if (istep_o && imem_we_o) rrem_q <= rrem_q - CNT_W'(1);
      if (istep_o && !imem_we_o) buf_o <= imem_rdata_i;
      if (erstep_o) buf_o <= emem_rdata_i;
    end
  end
endmodule

// File: rtl/dly_dma_seq.sv
module dly_dma_seq #(
  parameter int IADDR_W = 12,
  parameter int EADDR_W = 16,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 8,
  parameter int CFG_W   = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [2:0]         cfg_sel_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  input  logic               start_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               imem_req_o,
  output logic               imem_we_o,
  output logic [IADDR_W-1:0] imem_addr_o,
  output logic [DATA_W-1:0]  imem_wdata_o,
  input  logic [DATA_W-1:0]  imem_rdata_i,
  input  logic               imem_ack_i,
  output logic               emem_req_o,
  output logic               emem_we_o,
  output logic [EADDR_W-1:0] emem_addr_o,
  output logic [DATA_W-1:0]  emem_wdata_o,
  input  logic [DATA_W-1:0]  emem_rdata_i,
  input  logic               emem_ack_i
);
  logic [IADDR_W-1:0] iptr_cfg, istp_cfg;
  logic [EADDR_W-1:0] eptr_cfg, estp_cfg, rptr_cfg;
  logic [CNT_W-1:0]   wcnt_cfg, rcnt_cfg;
  logic               load, istep, ewstep, erstep;
  logic [DATA_W-1:0]  buf_q;
  logic [EADDR_W-1:0] ew_ptr, er_ptr;

  dly_dma_regs #(.IADDR_W(IADDR_W), .EADDR_W(EADDR_W), .CNT_W(CNT_W), .CFG_W(CFG_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .sel_i(cfg_sel_i),
    .wdata_i(cfg_wdata_i), .lock_i(busy_o),
    .iptr_o(iptr_cfg), .istp_o(istp_cfg), .wcnt_o(wcnt_cfg), .eptr_o(eptr_cfg),
    .estp_o(estp_cfg), .rcnt_o(rcnt_cfg), .rptr_o(rptr_cfg)
  );

  dly_dma_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .wcnt_i(wcnt_cfg), .rcnt_i(rcnt_cfg),
    .imem_ack_i(imem_ack_i), .emem_ack_i(emem_ack_i),
    .imem_rdata_i(imem_rdata_i), .emem_rdata_i(emem_rdata_i),
    .busy_o(busy_o), .done_o(done_o),
    .imem_req_o(imem_req_o), .imem_we_o(imem_we_o),
    .emem_req_o(emem_req_o), .emem_we_o(emem_we_o),
    .buf_o(buf_q), .load_o(load),
    .istep_o(istep), .ewstep_o(ewstep), .erstep_o(erstep)
  );

  dly_dma_ptr #(.W(IADDR_W)) u_iptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .load_val_i(iptr_cfg),
    .step_i(istep), .stp_i(istp_cfg), .ptr_o(imem_addr_o)
  );

  dly_dma_ptr #(.W(EADDR_W)) u_ewptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .load_val_i(eptr_cfg),
    .step_i(ewstep), .stp_i(estp_cfg), .ptr_o(ew_ptr)
  );

  dly_dma_ptr #(.W(EADDR_W)) u_erptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .load_val_i(rptr_cfg),
    .step_i(erstep), .stp_i(estp_cfg), .ptr_o(er_ptr)
  );

  assign emem_addr_o  = emem_we_o ? ew_ptr : er_ptr;
  assign emem_wdata_o = buf_q;
  assign imem_wdata_o = buf_q;
endmodule

// File: rtl/dly_dma_seq_chk.sv
module dly_dma_seq_chk #(
  parameter int IADDR_W = 12,
  parameter int EADDR_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               busy_o,
  input logic               done_o,
  input logic               imem_req_o,
  input logic               imem_ack_i,
  input logic [IADDR_W-1:0] imem_addr_o,
  input logic               emem_req_o,
  input logic               emem_we_o,
  input logic               emem_ack_i,
  input logic [EADDR_W-1:0] emem_addr_o
);
  a_r9_one_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(imem_req_o && emem_req_o));

  a_r9_ihold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imem_req_o && !imem_ack_i |=> imem_req_o && $stable(imem_addr_o));

  a_r9_ehold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emem_req_o && !emem_ack_i |=> emem_req_o && $stable(emem_addr_o) && $stable(emem_we_o));

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !imem_req_o && !emem_req_o && !done_o);

  a_r8_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o);

  a_r6_start_leaves_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i |=> busy_o);
endmodule

bind dly_dma_seq dly_dma_seq_chk #(.IADDR_W(IADDR_W), .EADDR_W(EADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .imem_req_o(imem_req_o), .imem_ack_i(imem_ack_i), .imem_addr_o(imem_addr_o),
  .emem_req_o(emem_req_o), .emem_we_o(emem_we_o), .emem_ack_i(emem_ack_i),
  .emem_addr_o(emem_addr_o)
);

// File: tb/dly_dma_seq_tb.sv
module dly_dma_seq_tb;
  localparam int IADDR_W = 12;
  localparam int EADDR_W = 16;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = 8;
  localparam int CFG_W   = 32;
  localparam int IMASK = (1 << IADDR_W) - 1;
  localparam int EMASK = (1 << EADDR_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic               cfg_we = 1'b0;
  logic [2:0]         cfg_sel = '0;
  logic [CFG_W-1:0]   cfg_wdata = '0;
  logic               start = 1'b0;
  logic               busy, done;
  logic               imem_req, imem_we, imem_ack;
  logic [IADDR_W-1:0] imem_addr;
  logic [DATA_W-1:0]  imem_wdata, imem_rdata;
  logic               emem_req, emem_we, emem_ack;
  logic [EADDR_W-1:0] emem_addr;
  logic [DATA_W-1:0]  emem_wdata, emem_rdata;

  dly_dma_seq #(.IADDR_W(IADDR_W), .EADDR_W(EADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .CFG_W(CFG_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .start_i(start), .busy_o(busy), .done_o(done),
    .imem_req_o(imem_req), .imem_we_o(imem_we), .imem_addr_o(imem_addr),
    .imem_wdata_o(imem_wdata), .imem_rdata_i(imem_rdata), .imem_ack_i(imem_ack),
    .emem_req_o(emem_req), .emem_we_o(emem_we), .emem_addr_o(emem_addr),
    .emem_wdata_o(emem_wdata), .emem_rdata_i(emem_rdata), .emem_ack_i(emem_ack)
  );

  function automatic logic [DATA_W-1:0] ifn(int unsigned a);
    return 32'h1000_0000 ^ (a * 32'h0000_9E37);
  endfunction
  function automatic logic [DATA_W-1:0] efn(int unsigned a);
    return 32'h5A00_0000 + a * 3;
  endfunction

  assign imem_rdata = ifn(int'(imem_addr));
  assign emem_rdata = efn(int'(emem_addr));

  // memory models: ack after 0..2 extra wait cycles, one cycle wide
  int iwait, ewait, ilat, elat;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imem_ack <= 1'b0; emem_ack <= 1'b0; iwait <= 0; ewait <= 0;
      ilat <= 0; elat <= 1;
    end else begin
      if (imem_ack) imem_ack <= 1'b0;
      else if (imem_req) begin
        if (iwait >= ilat) begin
          imem_ack <= 1'b1; iwait <= 0; ilat <= int'($urandom_range(0, 2));
        end else iwait <= iwait + 1;
      end
      if (emem_ack) emem_ack <= 1'b0;
      else if (emem_req) begin
        if (ewait >= elat) begin
          emem_ack <= 1'b1; ewait <= 0; elat <= int'($urandom_range(0, 2));
        end else ewait <= ewait + 1;
      end
    end
  end

  typedef struct {
    int          kind; // 0 int read, 1 ext write, 2 ext read, 3 int write
    int unsigned addr;
    logic [DATA_W-1:0] data;
  } ev_t;

  ev_t exp_q[$];
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int ref_cyc = 0;
  int done_cnt = 0;
  int ewr_cnt = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic string kreq(int k);
    case (k)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R5";
    endcase
  endfunction

  // monitor: pop expected transfers and compare
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if ((imem_req && imem_ack) || (emem_req && emem_ack)) begin
        int k;
        int unsigned a;
        logic [DATA_W-1:0] d;
        if (imem_req) begin
          k = imem_we ? 3 : 0; a = int'(imem_addr); d = imem_wdata;
        end else begin
          k = emem_we ? 1 : 2; a = int'(emem_addr); d = emem_wdata;
        end
        if (k == 1) ewr_cnt++;
        ref_cyc = cyc;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected transfer kind", k, -1);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          chk(k == e.kind, "R2", "transfer kind/order", k, e.kind);
          chk(a == e.addr, kreq(e.kind), "address", a, e.addr);
          if (e.kind == 1 || e.kind == 3)
            chk(d == e.data, (e.kind == 1) ? "R2" : "R5", "write data", d, e.data);
        end
      end
      if (done) begin
        done_cnt++;
        chk(cyc == ref_cyc + 1, "R7", "done cycle offset", cyc - ref_cyc, 1);
        chk(exp_q.size() == 0, "R7", "transfers left at done", exp_q.size(), 0);
      end
    end
  end

  task automatic cfg_wr(input int sel, input int unsigned val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // driver: program, queue expectations, start, wait for completion
  task automatic run_access(input bit prog, input int unsigned ip, input int unsigned is,
                            input int wc, input int unsigned ep, input int unsigned es,
                            input int rc, input int unsigned rp, input bit poke);
    int unsigned i_p, e_p, r_p;
    int d0;
    if (prog) begin
      cfg_wr(0, ip); cfg_wr(1, is); cfg_wr(2, wc); cfg_wr(3, ep);
      cfg_wr(4, es); cfg_wr(5, rc); cfg_wr(6, rp);
      cfg_wr(7, 32'hFFFF_FFFF); // R10: code 7 ignored
    end
    i_p = ip & IMASK; e_p = ep & EMASK; r_p = rp & EMASK;
    for (int n = 0; n < wc; n++) begin
      exp_q.push_back('{0, i_p, ifn(i_p)});
      exp_q.push_back('{1, e_p, ifn(i_p)});
      i_p = (i_p + is) & IMASK;
      e_p = (e_p + es) & EMASK;
    end
    for (int n = 0; n < rc; n++) begin
      exp_q.push_back('{2, r_p, '0});
      exp_q.push_back('{3, i_p, efn(r_p)});
      i_p = (i_p + is) & IMASK;
      r_p = (r_p + es) & EMASK;
    end
    ewr_cnt = 0;
    d0 = done_cnt;
    @(negedge clk);
    start = 1'b1;
    ref_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8", "busy after start", busy, 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      // R8: these must be dropped
      cfg_we = 1'b1; cfg_sel = 3'd3; cfg_wdata = 32'h0000_7777; start = 1'b1;
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 3'd2; cfg_wdata = 32'd1;
      @(negedge clk);
      cfg_we = 1'b0; start = 1'b0;
    end
    for (int t = 0; t < 5000 && done_cnt == d0; t++) @(negedge clk);
    chk(done_cnt == d0 + 1, "R7", "done pulses", done_cnt - d0, 1);
    chk(ewr_cnt == wc, "R2", "external write count", ewr_cnt, wc);
    @(negedge clk);
    chk(!done && !busy, "R7", "done/busy after pulse", {done, busy}, 0);
    exp_q.delete();
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !imem_req && !emem_req, "R1", "outputs in reset",
        {busy, done, imem_req, emem_req}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !imem_req && !emem_req, "R1", "outputs after reset",
        {busy, done, imem_req, emem_req}, 0);

    // R2 R3 R4 R5 R10: plain unit steps
    run_access(1, 32'h010, 1, 4, 32'h100, 1, 4, 32'h100, 0);
    // R3 R4: negative steps with wrap
    run_access(1, 32'h001, 32'hFFFF_FFFF, 3, 32'h0002, 32'hFFFF_FFFE, 3, 32'h0001, 0);
    // R6: zero write count
    run_access(1, 32'h020, 2, 0, 32'h0, 4, 3, 32'h0400, 0);
    // R6: zero read count
    run_access(1, 32'h030, 3, 2, 32'h0800, 8, 0, 32'h0, 0);
    // R6: both zero
    run_access(1, 32'h040, 1, 0, 32'h0, 1, 0, 32'h0, 0);
    // R8: writes and start while busy dropped
    run_access(1, 32'h050, 1, 5, 32'h1000, 2, 2, 32'h1000, 1);
    // R8: rerun without reprogramming, old values still in force
    run_access(0, 32'h050, 1, 5, 32'h1000, 2, 2, 32'h1000, 0);
    // larger block, long phases
    run_access(1, 32'hFF0, 5, 40, 32'hFFF0, 3, 40, 32'hFFF0, 0);
    summary();
  end
endmodule